// File: doc/BRIEF.md
# Serial Flash Write Sequencer

This block programs an SPI serial flash from a simple parallel request port. A request carries a 24-bit target address, a mode bit and, depending on the mode, either one data byte or a byte count. An accepted request makes the block run a fixed series of chip-select frames on the SPI pins. It first checks the device status and then sets the write-enable latch. Next it sends the program command with the address and the data. Last, it polls the status until the device reports that it has finished. Only then does the block pulse `done` and drop `busy`.

In single-byte mode the data byte comes with the request, so writing N bytes this way costs N complete sequences and N programming waits. In page mode the request carries a count, and the payload arrives through a byte-wide valid/ready stream while the program frame is open. Up to one full page goes out in a single frame. Wrapping at a page boundary is left to the flash: the block sends the start address unchanged.

Top module: `sfw_sequencer`

## Requirements
- R1: After reset, `busy`, `done`, `dat_ready` and `spi_sck` are low and `spi_cs_n` is high.
- R2: A request is taken only while `busy` is low. `cmd_valid` raised while `busy` is high is dropped: it is not queued and causes no SPI frame.
- R3: Every write opens with a status frame. This is opcode 0x05 followed by one read byte. The frame repeats for as long as the busy flag, bit 0 of the returned status byte, reads 1.
- R4: After that check comes a frame holding exactly one byte, the write-enable opcode 0x06.
- R5: The program frame carries opcode 0x02, then the 24-bit address with the most significant byte first, then the data. In single-byte mode the data is exactly the one byte taken from `cmd_data`.
- R6: In page mode the frame carries `cmd_len`+1 bytes (1 to 256), taken from `dat_in` in arrival order through `dat_valid`/`dat_ready`. `dat_ready` is never high in single-byte mode.
- R7: The address is sent exactly as requested, even when the page payload runs past a 256-byte boundary. The whole payload goes out in that one frame, and the device wraps it within the page.
- R8: After the program frame, status frames repeat until bit 0 reads 0. `done` is then high for exactly one clock, and `busy` is low in that same clock.
- R9: SPI mode 0 applies. `spi_sck` idles low and is low whenever `spi_cs_n` is high. `spi_mosi` holds steady while `spi_sck` is high, and `spi_miso` is sampled on the rising edge.
- R10: Between any two frames, `spi_cs_n` stays high for at least `GAP_SPI_CLKS` SPI clock periods.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Request strobe |
| cmd_page | input | 1 | 1 = page mode, 0 = single-byte mode |
| cmd_addr | input | 24 | Target flash address |
| cmd_len | input | $clog2(PAGE_BYTES) | Page payload length minus one |
| cmd_data | input | 8 | Data byte for single-byte mode |
| dat_valid | input | 1 | Page payload byte valid |
| dat_in | input | 8 | Page payload byte |
| dat_ready | output | 1 | Block takes `dat_in` this cycle when `dat_valid` is high |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| spi_sck | output | 1 | SPI clock |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_mosi | output | 1 | SPI data to the flash |
| spi_miso | input | 1 | SPI data from the flash |

## Verification
The flash model can hold the busy flag high at the start of a request. A sequencer that skipped the opening check would then send write-enable while the device was still busy, and the model's frame log shows that at once. After each program frame the model stays busy for a set number of polls. A design that ended early, or read the wrong status bit, would pulse `done` too soon or never finish. The bench sends page payloads with stalls in the stream, runs a full 256-byte page, and runs one payload that crosses a page boundary: a design that split that frame or adjusted its address would leave misplaced bytes in model memory. A request raised mid-sequence must leave no trace: a design that queued it would start a second program frame after `done`.

// File: rtl/sfw_pkg.sv
package sfw_pkg;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam int HDR_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_GAP, ST_CHK, ST_WREN, ST_PROG, ST_POLL
  } seq_state_t;

  // busy flag position inside the returned status byte
  function automatic logic sr_busy(input logic [7:0] sr);
    return sr[0];
  endfunction

  // header of a program frame: opcode then address, high byte first
  function automatic logic [7:0] prog_hdr(input logic [23:0] a, input logic [1:0] idx);
    case (idx)
      2'd0:    return OP_PROG;
      2'd1:    return a[23:16];
      2'd2:    return a[15:8];
      default: return a[7:0];
    endcase
  endfunction
endpackage

// File: rtl/sfw_spi_byte.sv
module sfw_spi_byte #(
  parameter int CLK_DIV = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [7:0] tx,
  input  logic       miso,
  output logic       sck,
  output logic       mosi,
  output logic       done,
  output logic [7:0] rx
);
  localparam int DW = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;

  logic [DW-1:0] div;
  logic [7:0]    sh;
  logic [2:0]    bitn;
  logic          act;
  logic          tick;

  assign tick = act && (div == DW'(CLK_DIV - 1));
  assign mosi = sh[7];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div  <= '0;
      sh   <= '0;
      bitn <= '0;
      act  <= 1'b0;
      sck  <= 1'b0;
      done <= 1'b0;
      rx   <= '0;
    end else begin
      done <= 1'b0;
      if (start) begin
        act  <= 1'b1;
        sh   <= tx;
        bitn <= '0;
        div  <= '0;
        sck  <= 1'b0;
      end else if (act) begin
        div <= tick ? '0 : div + 1'b1;
        if (tick) begin
          if (!sck) begin
            sck <= 1'b1;
            rx  <= {rx[6:0], miso};
          end else begin
            sck <= 1'b0;
            if (bitn == 3'd7) begin
              act  <= 1'b0;
              done <= 1'b1;
            end else begin
              bitn <= bitn + 1'b1;
              sh   <= {sh[6:0], 1'b0};
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/sfw_gap_timer.sv
module sfw_gap_timer #(
  parameter int GAP_CLKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic expired
);
  localparam int GW = $clog2(GAP_CLKS + 1);

  logic [GW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)           cnt <= '0;
    else if (load)        cnt <= GW'(GAP_CLKS);
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0) && !load;
endmodule

// File: rtl/sfw_sequencer.sv
module sfw_sequencer
  import sfw_pkg::*;
#(
  parameter int CLK_DIV      = 2,
  parameter int GAP_SPI_CLKS = 2,
  parameter int PAGE_BYTES   = 256
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cmd_valid,
  input  logic                          cmd_page,
  input  logic [23:0]                   cmd_addr,
  input  logic [$clog2(PAGE_BYTES)-1:0] cmd_len,
  input  logic [7:0]                    cmd_data,
  input  logic                          dat_valid,
  input  logic [7:0]                    dat_in,
  output logic                          dat_ready,
  output logic                          busy,
  output logic                          done,
  output logic                          spi_sck,
  output logic                          spi_cs_n,
  output logic                          spi_mosi,
  input  logic                          spi_miso
);
  localparam int LEN_W    = $clog2(PAGE_BYTES);
  localparam int FIDX_W   = LEN_W + 2;
  localparam int GAP_CLKS = 2 * CLK_DIV * GAP_SPI_CLKS;

  seq_state_t        state, after_st;
  logic [FIDX_W-1:0] fidx, nidx, last_idx;
  logic [23:0]       addr_q;
  logic              page_q;
  logic [LEN_W-1:0]  len_q;
  logic [7:0]        byte_q;
  logic              waiting;
  logic              eng_start, eng_done;
  logic [7:0]        eng_tx, eng_rx;
  logic              gap_load, gap_expired;
  logic              cs_q, done_q;

  // named events for the checker
  logic cmd_accept, frame_end, dev_busy;

  function automatic logic [7:0] frame_byte(input seq_state_t st, input logic [FIDX_W-1:0] idx,
                                            input logic [23:0] a, input logic [7:0] d);
    case (st)
      ST_WREN: frame_byte = OP_WREN;
      ST_PROG: frame_byte = (idx < FIDX_W'(HDR_BYTES)) ? prog_hdr(a, idx[1:0]) : d;
      default: frame_byte = (idx == '0) ? OP_RDSR : 8'h00;
    endcase
  endfunction

  always_comb begin
    case (state)
      ST_WREN: last_idx = '0;
      ST_PROG: last_idx = page_q ? FIDX_W'(HDR_BYTES) + FIDX_W'(len_q) : FIDX_W'(HDR_BYTES);
      default: last_idx = FIDX_W'(1);
    endcase
  end

  assign busy       = (state != ST_IDLE);
  assign cmd_accept = cmd_valid && (state == ST_IDLE);
  assign frame_end  = eng_done && (fidx == last_idx);
  assign dev_busy   = sr_busy(eng_rx);
  assign nidx       = fidx + 1'b1;
  assign dat_ready  = (state == ST_PROG) && waiting;
  assign spi_cs_n   = cs_q;
  assign done       = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      after_st  <= ST_CHK;
      fidx      <= '0;
      addr_q    <= '0;
      page_q    <= 1'b0;
      len_q     <= '0;
      byte_q    <= '0;
      waiting   <= 1'b0;
      eng_start <= 1'b0;
      eng_tx    <= '0;
      gap_load  <= 1'b0;
      cs_q      <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      gap_load  <= 1'b0;
      done_q    <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (cmd_accept) begin
            addr_q   <= cmd_addr;
            page_q   <= cmd_page;
            len_q    <= cmd_len;
            byte_q   <= cmd_data;
            after_st <= ST_CHK;
            gap_load <= 1'b1;
            state    <= ST_GAP;
          end
        end
        ST_GAP: begin
          if (gap_expired) begin
            state     <= after_st;
            cs_q      <= 1'b0;
            fidx      <= '0;
            eng_start <= 1'b1;
            eng_tx    <= frame_byte(after_st, '0, addr_q, byte_q);
          end
        end
        default: begin
          if (waiting && dat_valid) begin
            waiting   <= 1'b0;
            eng_start <= 1'b1;
            eng_tx    <= dat_in;
          end
          if (eng_done) begin
            if (frame_end) begin
              cs_q     <= 1'b1;
              gap_load <= 1'b1;
              state    <= ST_GAP;
              case (state)
                ST_CHK:  after_st <= dev_busy ? ST_CHK : ST_WREN;
                ST_WREN: after_st <= ST_PROG;
                ST_PROG: after_st <= ST_POLL;
                default: begin
                  if (dev_busy) after_st <= ST_POLL;
                  else begin
                    state  <= ST_IDLE;
                    done_q <= 1'b1;
                  end
                end
              endcase
            end else begin
              fidx <= nidx;
              if (state == ST_PROG && page_q && nidx >= FIDX_W'(HDR_BYTES)) begin
                waiting <= 1'b1;
              end else begin
                eng_start <= 1'b1;
                eng_tx    <= frame_byte(state, nidx, addr_q, byte_q);
              end
            end
          end
        end
      endcase
    end
  end

  sfw_spi_byte #(.CLK_DIV(CLK_DIV)) u_byte (
    .clk   (clk),
    .rst_n (rst_n),
    .start (eng_start),
    .tx    (eng_tx),
    .miso  (spi_miso),
    .sck   (spi_sck),
    .mosi  (spi_mosi),
    .done  (eng_done),
    .rx    (eng_rx)
  );

  sfw_gap_timer #(.GAP_CLKS(GAP_CLKS)) u_gap (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (gap_load),
    .expired (gap_expired)
  );
endmodule

// File: rtl/sfw_checker.sv
module sfw_checker #(
  parameter int GAP_CLKS = 8
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic cmd_accept,
  input logic frame_end,
  input logic dat_ready,
  input logic page_q,
  input logic spi_cs_n,
  input logic spi_sck,
  input logic spi_mosi
);
  localparam int HW = $clog2(GAP_CLKS + 1) + 1;

  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                         hi_cnt <= '0;
    else if (!spi_cs_n)                 hi_cnt <= '0;
    else if (hi_cnt < HW'(GAP_CLKS))    hi_cnt <= hi_cnt + 1'b1;
  end

  assert_accept_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_accept |=> busy);

  assert_frame_close_R4: assert property (@(posedge clk) disable iff (!rst_n)
    frame_end |=> spi_cs_n);

  assert_ready_page_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dat_ready |-> (page_q && !spi_cs_n && busy));

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_sck_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  assert_cs_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(spi_cs_n) |-> (hi_cnt >= HW'(GAP_CLKS)));
endmodule

bind sfw_sequencer sfw_checker #(.GAP_CLKS(GAP_CLKS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .done       (done),
  .cmd_accept (cmd_accept),
  .frame_end  (frame_end),
  .dat_ready  (dat_ready),
  .page_q     (page_q),
  .spi_cs_n   (spi_cs_n),
  .spi_sck    (spi_sck),
  .spi_mosi   (spi_mosi)
);

// File: tb/tb_sfw_sequencer.sv
`timescale 1ns/1ps
module tb_sfw_sequencer;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_page = 1'b0;
  logic [23:0] cmd_addr = '0;
  logic [7:0]  cmd_len = '0, cmd_data = '0;
  logic dat_valid = 1'b0;
  logic [7:0] dat_in = '0;
  logic dat_ready, busy, done, spi_sck, spi_cs_n, spi_mosi, spi_miso;

  always #4 clk = ~clk;  // 125 MHz

  sfw_sequencer dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_page(cmd_page),
    .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_data(cmd_data),
    .dat_valid(dat_valid), .dat_in(dat_in), .dat_ready(dat_ready),
    .busy(busy), .done(done), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  int tests = 0, fails = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // ---------------- flash model ----------------
  logic [7:0] mem [0:4095];
  logic [7:0] fr_bytes [0:263];
  logic [7:0] fr_shift = '0;
  logic [7:0] st_snap = '0;
  int fr_bits = 0, fr_nbytes = 0;
  int busy_left = 0, prog_polls = 0, n_prog = 0, last_cnt = 0;
  logic wel = 1'b0;
  logic [23:0] last_addr = '0;
  logic [7:0] seq [0:63];
  int seq_nb [0:63];
  int seq_len = 0;

  assign spi_miso = (fr_nbytes >= 1 && fr_bytes[0] == 8'h05) ? st_snap[3'(7 - (fr_bits % 8))] : 1'b0;

  always @(negedge spi_cs_n) begin
    fr_bits = 0;
    fr_nbytes = 0;
    st_snap = {6'b0, wel, (busy_left > 0)};
  end

  always @(posedge spi_sck) if (!spi_cs_n) begin
    fr_shift = {fr_shift[6:0], spi_mosi};
    fr_bits++;
    if (fr_bits % 8 == 0 && fr_nbytes < 264) begin
      fr_bytes[fr_nbytes] = fr_shift;
      fr_nbytes++;
    end
  end

  always @(posedge spi_cs_n) if (rst_n && fr_nbytes > 0) begin
    if (seq_len < 64) begin
      seq[seq_len] = fr_bytes[0];
      seq_nb[seq_len] = fr_nbytes;
      seq_len++;
    end
    case (fr_bytes[0])
      8'h05: if (busy_left > 0) busy_left--;
      8'h06: if (fr_nbytes == 1) wel = 1'b1;
      8'h02: if (wel && fr_nbytes >= 5) begin
        last_addr = {fr_bytes[1], fr_bytes[2], fr_bytes[3]};
        last_cnt = fr_nbytes - 4;
        for (int i = 0; i < fr_nbytes - 4; i++)
          mem[{last_addr[11:8], 8'(last_addr[7:0] + i)}] = fr_bytes[4 + i];
        busy_left = prog_polls;
        wel = 1'b0;
        n_prog++;
      end
      default: ;
    endcase
  end

  int done_cnt = 0, dr_cnt = 0;
  always @(negedge clk) if (rst_n) begin
    if (done) done_cnt++;
    if (dat_ready) dr_cnt++;
  end

  // ---------------- helpers ----------------
  function automatic logic [7:0] pat(input logic [7:0] base, input int i);
    return 8'(base + i * 7);
  endfunction

  task automatic clear_log();
    seq_len = 0; done_cnt = 0; dr_cnt = 0;
  endtask

  task automatic issue(input logic page, input logic [23:0] a, input logic [7:0] len, input logic [7:0] d);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_page = page; cmd_addr = a; cmd_len = len; cmd_data = d;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (done_cnt == 0 && n < 40000) begin @(negedge clk); n++; end
    check({req, " completion seen"}, 32'(done_cnt > 0), 32'd1);
  endtask

  task automatic feed(input int cnt, input logic [7:0] base);
    int i = 0, k = 0;
    bit xfer;
    @(posedge clk); #1;
    dat_valid = 1'b1; dat_in = pat(base, 0);
    while (i < cnt) begin
      @(negedge clk);
      xfer = dat_valid && dat_ready;
      @(posedge clk); #1;
      if (xfer) i++;
      k++;
      dat_valid = (i < cnt) && ((k % 4) != 3);
      dat_in = pat(base, i);
    end
    dat_valid = 1'b0;
  endtask

  task automatic page_write(input string req, input logic [23:0] a, input int cnt, input logic [7:0] base);
    clear_log(); busy_left = 0; prog_polls = 2;
    issue(1'b1, a, 8'(cnt - 1), 8'h00);
    feed(cnt, base);
    wait_done(req);
    check({req, " frame count"}, 32'(seq_len), 32'd6);
    check({req, " program frame length"}, 32'(seq_nb[2]), 32'(cnt + 4));
    check({req, " address sent"}, 32'(last_addr), 32'(a));
  endtask

  // ---------------- scenarios ----------------
  task automatic t_reset();
    check("R1 busy", 32'(busy), 0);
    check("R1 done", 32'(done), 0);
    check("R1 dat_ready", 32'(dat_ready), 0);
    check("R1 sck", 32'(spi_sck), 0);
    check("R1 cs_n", 32'(spi_cs_n), 1);
  endtask

  task automatic t_single();
    clear_log(); busy_left = 0; prog_polls = 3;
    issue(1'b0, 24'h0012A5, 8'h00, 8'h3C);
    wait_done("R8 single");
    check("R3 first frame opcode", 32'(seq[0]), 32'h05);
    check("R3 status frame length", 32'(seq_nb[0]), 2);
    check("R4 enable opcode", 32'(seq[1]), 32'h06);
    check("R4 enable frame length", 32'(seq_nb[1]), 1);
    check("R5 program opcode", 32'(seq[2]), 32'h02);
    check("R5 single frame length", 32'(seq_nb[2]), 5);
    check("R5 address", 32'(last_addr), 32'h0012A5);
    check("R5 data written", 32'(mem[12'h2A5]), 32'h3C);
    check("R8 poll frames until clear", 32'(seq_len), 7);
    check("R8 last poll opcode", 32'(seq[6]), 32'h05);
    check("R8 one done pulse", 32'(done_cnt), 1);
    check("R8 busy low at end", 32'(busy), 0);
    check("R6 no ready in single mode", 32'(dr_cnt), 0);
    // second byte pays the whole sequence again
    clear_log(); prog_polls = 0;
    issue(1'b0, 24'h0012A6, 8'h00, 8'hC3);
    wait_done("R5 second single");
    check("R5 second single full sequence", 32'(seq_len), 4);
    check("R4 second single enable", 32'(seq[1]), 32'h06);
    check("R5 second byte written", 32'(mem[12'h2A6]), 32'hC3);
  endtask

  task automatic t_prebusy();
    clear_log(); busy_left = 2; prog_polls = 1;
    issue(1'b0, 24'h000210, 8'h00, 8'h5A);
    wait_done("R3 prebusy");
    check("R3 repeated status checks", 32'(seq[2]), 32'h05);
    check("R3 enable after clear", 32'(seq[3]), 32'h06);
    check("R3 total frames", 32'(seq_len), 7);
    check("R3 data written", 32'(mem[12'h210]), 32'h5A);
  endtask

  task automatic t_page(input logic [23:0] a, input int cnt, input logic [7:0] base, input string req);
    int bad = 0;
    page_write(req, a, cnt, base);
    for (int i = 0; i < cnt; i++)
      if (mem[{a[11:8], 8'(a[7:0] + i)}] !== pat(base, i)) bad++;
    check({req, " payload order"}, 32'(bad), 0);
    check({req, " byte count"}, 32'(last_cnt), 32'(cnt));
  endtask

  task automatic t_ignore();
    int np;
    clear_log(); busy_left = 0; prog_polls = 5; np = n_prog;
    mem[12'h701] = 8'hFF;
    issue(1'b0, 24'h000700, 8'h00, 8'h11);
    repeat (40) @(negedge clk);
    check("R2 busy during sequence", 32'(busy), 1);
    issue(1'b0, 24'h000701, 8'h00, 8'h22);
    wait_done("R2 ignore");
    repeat (300) @(negedge clk);
    check("R2 one program frame", 32'(n_prog - np), 1);
    check("R2 no extra frames", 32'(seq_len), 9);
    check("R2 dropped request left memory", 32'(mem[12'h701]), 32'hFF);
    check("R2 accepted data", 32'(mem[12'h700]), 32'h11);
    check("R2 idle after", 32'(busy), 0);
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem[i] = 8'hFF;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_prebusy();
    t_page(24'h000340, 16, 8'h10, "R6 page16");
    t_page(24'h000500, 256, 8'h01, "R6 page256");
    t_page(24'h0006F8, 16, 8'h80, "R7 wrap");
    check("R7 wrapped byte at page base", 32'(mem[12'h600]), 32'(pat(8'h80, 8)));
    check("R7 byte before boundary", 32'(mem[12'h6FF]), 32'(pat(8'h80, 7)));
    t_ignore();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule